// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block is a behavioural, synthesizable model of a single I/O pad cell. One 6-bit constant, `MODE`, is fixed at elaboration and chooses three paths. The enable path decides whether the cell drives the pad. The output path either passes data straight through or forms a double-data-rate stream from two registers. The input path either follows the pad, samples it on an input clock, or holds it in a transparent latch. A second input bit is always taken on the falling edge of the input clock.

The pad is modelled without tristate nets. The cell reports its drive value and its drive enable on two ports. An external agent reports its own drive through a pair of inputs. The cell resolves the level it senses from these signals. If nobody drives the pad, the level falls back to an optional weak pull-up. Three `MODE` values are typical: `6'b101001` gives a bidirectional pin with no registers, `6'b001001` a plain input and `6'b011001` a plain output.

Top module: `cfg_io_cell`

## Requirements
- R1: With MODE[5]=1 and MODE[4]=0, `pad_en` equals `oe_in` in the same cycle, with no register in the path.
- R2: With MODE[5]=1 and MODE[4]=1, `pad_en` equals the value `oe_in` had at the latest rising edge of `clk_out`.
- R3: With MODE[5]=0, `pad_en` is held at MODE[4] (1 means always output, 0 means always input), and `oe_in` has no effect on it.
- R4: With MODE[3]=1, `pad_drv` equals `dout0` with no register in the path, and `dout1` has no effect on it.
- R5: With MODE[3]=0 and MODE[2]=0, `pad_drv` shows two values. While `clk_out` is high it shows `dout0` as captured at the latest rising edge of `clk_out`. While `clk_out` is low it shows `dout1` as captured at the latest falling edge.
- R6: With MODE[3]=0 and MODE[2]=1, the two phases swap. While `clk_out` is low, `pad_drv` shows `dout0` from the latest rising edge. While `clk_out` is high, it shows `dout1` from the latest falling edge. `dout1` is never sampled on a rising edge.
- R7: The sensed pad level is chosen in priority order. If `pad_en` is 1, it is `pad_drv`, and the cell's own drive wins over an external one. Otherwise, if `pad_ext_en` is 1, it is `pad_ext`. Otherwise it is 1 when `PULL_UP` is 1 and 0 when `PULL_UP` is 0.
- R8: With MODE[1]=1, `din0` follows the pad level while `hold_in` is 0. While `hold_in` is 1, `din0` keeps the level it had when `hold_in` rose. MODE[0] has no effect in this case.
- R9: With MODE[1]=0 and MODE[0]=1, `din0` equals the pad level with no register in the path.
- R10: With MODE[1:0]=00, `din0` equals the pad level sampled at the latest rising edge of `clk_in`.
- R11: In every mode, `din1` equals the pad level sampled at the latest falling edge of `clk_in`.
- R12: `rst` is active high and synchronous. While it is high, every register clears to 0 at the next active edge of its own clock: the enable register, both output registers and both input registers. The input latch is not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_out | input | 1 | Output clock for the enable register and the DDR output registers |
| clk_in | input | 1 | Input clock for the rising-edge and falling-edge input registers |
| rst | input | 1 | Synchronous active-high reset, sampled by each clock |
| oe_in | input | 1 | Requested drive enable |
| dout0 | input | 1 | Output data bit 0 (direct data, or rising-edge DDR data) |
| dout1 | input | 1 | Output data bit 1 (falling-edge DDR data) |
| hold_in | input | 1 | Input latch control: 0 means transparent, 1 means hold |
| pad_ext_en | input | 1 | An external agent is driving the pad |
| pad_ext | input | 1 | Value driven by the external agent |
| pad_drv | output | 1 | Value the cell drives onto the pad |
| pad_en | output | 1 | The cell drives the pad |
| din0 | output | 1 | Captured input bit 0 |
| din1 | output | 1 | Input bit 1, captured on the falling edge of `clk_in` |

## Verification
The in-module properties check the clocked relations on every edge. These are the delay of the registered enable and its clearing on reset, the rising-edge and falling-edge sampling of the pad level into `din0` and `din1`, and the stability of `din0` while the latch holds. What the properties cannot show is the value on `pad_drv` inside each half period of the DDR phases, the pull-up fallback when nothing drives the pad, and the priority of the cell's own drive over an external one. The bench shows these by running eight cells with different modes side by side. It compares each cell against a behavioural model in both halves of every clock period.

// File: rtl/cfg_io_cell.sv
`timescale 1ns/1ps
module cfg_io_cell #(
  parameter logic [5:0] MODE    = 6'b101001,
  parameter bit         PULL_UP = 1'b0
) (
  input  logic clk_out,
  input  logic clk_in,
  input  logic rst,
  input  logic oe_in,
  input  logic dout0,
  input  logic dout1,
  input  logic hold_in,
  input  logic pad_ext_en,
  input  logic pad_ext,
  output logic pad_drv,
  output logic pad_en,
  output logic din0,
  output logic din1
);

  localparam bit OE_USED  = MODE[5];
  localparam bit OE_SEL   = MODE[4];
  localparam bit OUT_DIR  = MODE[3];
  localparam bit DDR_SWAP = MODE[2];
  localparam bit IN_LATCH = MODE[1];
  localparam bit IN_DIR   = MODE[0];

  logic oe_q, rise_q, fall_q, in_q, in_fall_q, lat_q, pad_lvl;

  always_ff @(posedge clk_out)
    if (rst) begin
      oe_q   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      oe_q   <= oe_in;
      rise_q <= dout0;
    end

  always_ff @(negedge clk_out)
    if (rst) fall_q <= 1'b0;
    else     fall_q <= dout1;

  always_ff @(posedge clk_in)
    if (rst) in_q <= 1'b0;
    else     in_q <= pad_lvl;

  always_ff @(negedge clk_in)
    if (rst) in_fall_q <= 1'b0;
    else     in_fall_q <= pad_lvl;

  always_latch
    if (!hold_in) lat_q <= pad_lvl;

  assign pad_en  = OE_USED ? (OE_SEL ? oe_q : oe_in) : OE_SEL;
  assign pad_drv = OUT_DIR ? dout0 : ((clk_out ^ DDR_SWAP) ? rise_q : fall_q);
  assign pad_lvl = pad_en ? pad_drv : (pad_ext_en ? pad_ext : PULL_UP);
  assign din0    = IN_LATCH ? lat_q : (IN_DIR ? pad_lvl : in_q);
  assign din1    = in_fall_q;

  generate
    if (OE_USED && OE_SEL) begin : g_oe_chk
      // R2
      oe_delay_chk: assert property (@(posedge clk_out) disable iff (rst)
        !$past(rst) |-> pad_en == $past(oe_in));
      // R12
      oe_clear_chk: assert property (@(posedge clk_out) disable iff (rst)
        $past(rst) |-> !pad_en);
    end
    if (IN_LATCH) begin : g_lat_chk
      // R8
      latch_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
        (hold_in && $past(hold_in)) |-> $stable(din0));
    end
    if (!IN_LATCH && !IN_DIR) begin : g_inreg_chk
      // R10
      in_rise_chk: assert property (@(posedge clk_in) disable iff (rst)
        !$past(rst) |-> din0 == $past(pad_lvl));
    end
  endgenerate

  // R11
  in_fall_chk: assert property (@(negedge clk_in) disable iff (rst)
    !$past(rst) |-> din1 == $past(pad_lvl));

endmodule

// File: tb/cfg_io_cell_test.sv
`timescale 1ns/1ps
module cfg_io_cell_test;
  localparam int CLK_PERIOD = 20;
  localparam int NI = 8;
  localparam logic [5:0] MODES [NI] = '{6'b101001, 6'b001001, 6'b011001, 6'b010001,
                                       6'b010101, 6'b111010, 6'b001000, 6'b100111};
  localparam bit PULLS [NI] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk_o, clk_i;
  logic rst, oe_in, dout0, dout1, hold_in, ext_en, ext_val;
  logic o_drv [NI];
  logic o_en  [NI];
  logic o_d0  [NI];
  logic o_d1  [NI];

  bit m_oeq [NI];
  bit m_r0  [NI];
  bit m_r1  [NI];
  bit m_inq [NI];
  bit m_in1 [NI];
  bit m_held[NI];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  for (genvar g = 0; g < NI; g++) begin : lane
    cfg_io_cell #(.MODE(MODES[g]), .PULL_UP(PULLS[g])) uut (
      .clk_out(clk_o), .clk_in(clk_i), .rst(rst), .oe_in(oe_in),
      .dout0(dout0), .dout1(dout1), .hold_in(hold_in),
      .pad_ext_en(ext_en), .pad_ext(ext_val),
      .pad_drv(o_drv[g]), .pad_en(o_en[g]), .din0(o_d0[g]), .din1(o_d1[g]));
  end

  initial begin
    clk_o = 1'b0;
    forever #(CLK_PERIOD/2) clk_o = ~clk_o;
  end
  initial begin
    clk_i = 1'b0;
    #(CLK_PERIOD/4);
    forever #(CLK_PERIOD/2) clk_i = ~clk_i;
  end

  function automatic bit f_en(int k);
    logic [5:0] m = MODES[k];
    if (m[5]) return m[4] ? m_oeq[k] : oe_in;
    return m[4];
  endfunction

  function automatic bit f_drv(int k, bit high);
    logic [5:0] m = MODES[k];
    if (m[3]) return dout0;
    if (m[2]) return high ? m_r1[k] : m_r0[k];
    return high ? m_r0[k] : m_r1[k];
  endfunction

  function automatic bit f_lvl(int k, bit high);
    if (f_en(k)) return f_drv(k, high);
    if (ext_en) return ext_val;
    return PULLS[k];
  endfunction

  function automatic bit f_d0(int k, bit high);
    logic [5:0] m = MODES[k];
    if (m[1]) return hold_in ? m_held[k] : f_lvl(k, high);
    if (m[0]) return f_lvl(k, high);
    return m_inq[k];
  endfunction

  function automatic string t_en(int k);
    logic [5:0] m = MODES[k];
    return m[5] ? (m[4] ? "R2" : "R1") : "R3";
  endfunction
  function automatic string t_drv(int k);
    logic [5:0] m = MODES[k];
    return m[3] ? "R4" : (m[2] ? "R6" : "R5");
  endfunction
  function automatic string t_d0(int k);
    logic [5:0] m = MODES[k];
    return m[1] ? "R8" : (m[0] ? "R9" : "R10");
  endfunction

  task automatic chk(logic got, bit exp, string tag, string what, int k);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s lane%0d %s: got %b expected %b", tag, k, what, got, exp);
    end
  endtask

  task automatic chk_all(bit high);
    for (int k = 0; k < NI; k++) begin
      chk(o_en[k],  f_en(k),        t_en(k),  "pad_en",  k);
      chk(o_drv[k], f_drv(k, high), t_drv(k), "pad_drv", k);
      chk(o_d0[k],  f_d0(k, high),  t_d0(k),  "din0",    k);
      chk(o_d1[k],  m_in1[k],       "R11",    "din1",    k);
    end
  endtask

  task automatic cycle(bit nrst, bit noe, bit nd0, bit nd1, bit nhold, bit nee, bit nev);
    @(posedge clk_o);
    for (int k = 0; k < NI; k++) begin
      m_oeq[k] = rst ? 1'b0 : oe_in;
      m_r0[k]  = rst ? 1'b0 : dout0;
    end
    #2;
    if (nhold && !hold_in)
      for (int k = 0; k < NI; k++) m_held[k] = f_lvl(k, 1'b1);
    hold_in = nhold;
    #1;
    rst = nrst; oe_in = noe; dout0 = nd0; dout1 = nd1; ext_en = nee; ext_val = nev;
    @(posedge clk_i);
    for (int k = 0; k < NI; k++) m_inq[k] = rst ? 1'b0 : f_lvl(k, 1'b1);
    #2;
    chk_all(1'b1);
    @(negedge clk_o);
    for (int k = 0; k < NI; k++) m_r1[k] = rst ? 1'b0 : dout1;
    @(negedge clk_i);
    for (int k = 0; k < NI; k++) m_in1[k] = rst ? 1'b0 : f_lvl(k, 1'b0);
    #2;
    chk_all(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit h;
    rst = 1'b1; oe_in = 1'b0; dout0 = 1'b0; dout1 = 1'b0;
    hold_in = 1'b0; ext_en = 1'b0; ext_val = 1'b0;
    // R12: reset held with every data input high
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 1, 0, 1, 1);
    chk(o_en[5],  1'b0, "R12", "pad_en reset",       5);
    chk(o_drv[3], 1'b0, "R12", "pad_drv low reset",  3);
    chk(o_d0[6],  1'b0, "R12", "din0 reset",         6);
    chk(o_d1[1],  1'b0, "R12", "din1 reset",         1);
    cycle(0, 1, 1, 0, 0, 1, 0);
    // R7: undriven pad falls back to pull-up or to 0
    cycle(0, 0, 1, 1, 0, 0, 0);
    cycle(0, 0, 1, 1, 0, 0, 0);
    chk(o_d0[0], 1'b1, "R7", "pull-up level",  0);
    chk(o_d0[1], 1'b0, "R7", "no pull level",  1);
    chk(o_d0[6], 1'b1, "R7", "pull-up sample", 6);
    // R7: own drive wins over external drive
    cycle(0, 1, 1, 0, 0, 1, 0);
    chk(o_d0[0], 1'b1, "R7", "own drive wins", 0);
    chk(o_d0[1], 1'b0, "R7", "external seen",  1);
    // R8: hold latch across changing pad level
    cycle(0, 1, 1, 0, 0, 1, 1);
    cycle(0, 1, 0, 1, 1, 1, 0);
    cycle(0, 0, 1, 1, 1, 1, 0);
    cycle(0, 1, 0, 0, 0, 0, 1);
    h = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(3) == 0) h = ~h;
      cycle($urandom_range(49) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
            h, 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule